// File: doc/BRIEF.md
# Auto-Increment Pointer Data Port

This block gives a host access to a byte-addressed on-card RAM through three registers: a write pointer, a read pointer and a single data port. The host loads a pointer once. After that, each data-port access moves data between the host and the RAM at the pointer, and then advances that pointer by the size of the access. Accesses are either one byte or one 16-bit word. A word may start at any byte address, including an odd one, and it still completes in a single request. The block splits the RAM into an even-byte lane and an odd-byte lane, each with its own address, so that an unaligned word can update both lanes in one cycle.

The block also contains a memory-size probe. When started, it tries the largest RAM size first, then smaller sizes in fixed steps. For each trial size it clears the region with zero words, fills it with the word sequence 1, 4, 7, … (step 3) and reads the sequence back. It reports the first size whose read-back matches, or zero when every size fails. While the probe runs it owns the RAM, and the host port is locked out.

The probe is built around the states SZ_IDLE, SZ_CLEAR, SZ_FILL, SZ_CHECK, SZ_JUDGE and SZ_DONE, with these transitions:
- SZ_IDLE→SZ_CLEAR on start.
- SZ_CLEAR→SZ_FILL after the last zero word.
- SZ_FILL→SZ_CHECK after the last pattern word.
- SZ_CHECK→SZ_JUDGE after the last read is issued.
- SZ_JUDGE→SZ_CLEAR when the trial failed and a smaller size remains.
- SZ_JUDGE→SZ_DONE on a pass, or on a failure at the smallest size.
- SZ_DONE→SZ_CLEAR on a new start.

Top module: `dport_window`

## Requirements
- R1: The write pointer and the read pointer are separate. Writing host_sel=0 loads the write pointer and writing host_sel=1 loads the read pointer, each from host_wdata. Data writes use only the write pointer and data reads use only the read pointer. host_sel=2 selects the data port. host_sel=3, and any non-write request to host_sel 0 or 1, has no effect.
- R2: A byte data access (host_word=0) transfers host_wdata[7:0], or returns the byte in host_rdata[7:0] with the upper byte zero. It advances its pointer by 1 and enables exactly one RAM lane: the even lane (lo) for even addresses and the odd lane (hi) for odd addresses.
- R3: A word data access (host_word=1) is little-endian. The low byte is stored at the pointer address and the high byte at the next address. The access advances its pointer by 2 and enables both lanes.
- R4: A word access at an odd address completes in one request. The low byte goes to the odd address and the high byte goes to the following even address.
- R5: Pointers and byte addresses wrap modulo MAX_BYTES. A word at the last address places its high byte at address 0.
- R6: A data read returns host_rvalid=1 with host_rdata exactly one cycle after the request. No other request raises host_rvalid, and a read that directly follows a write to the same address returns the written data.
- R7: A 24-bit value written as two consecutive word writes, low word first, lands in four consecutive bytes as value[7:0], value[15:8], value[23:16], 0.
- R8: A transfer at an odd offset, done as a leading byte, then whole words, then a trailing byte, produces contiguous bytes in RAM.
- R9: A probe started with probe_start tries MAX_BYTES, then decreasing sizes in steps of STEP_BYTES. It clears, fills and verifies each trial region and reports the first passing size with probe_ok=1 and probe_done=1.
- R10: When no trial size passes, the probe ends with probe_done=1, probe_ok=0 and probe_bytes=0.
- R11: While host_busy=1, host requests are ignored. Neither pointer changes and no host_rvalid is produced.
- R12: After reset both pointers are 0, and host_busy, host_rvalid, probe_done, probe_ok and probe_bytes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 write pointer, 1 read pointer, 2 data port |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte |
| host_wdata | input | 16 | Write data or pointer value |
| host_busy | output | 1 | Probe owns the RAM; host requests ignored |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 16 | Read data |
| probe_start | input | 1 | Start a size probe |
| probe_done | output | 1 | Probe result valid |
| probe_ok | output | 1 | A trial size passed |
| probe_bytes | output | AW+1 | Detected RAM size in bytes |
| ram_en_lo | output | 1 | Even-lane enable |
| ram_we_lo | output | 1 | Even-lane write |
| ram_addr_lo | output | AW-1 | Even-lane word address |
| ram_wdata_lo | output | 8 | Even-lane write byte |
| ram_rdata_lo | input | 8 | Even-lane read byte, one cycle after enable |
| ram_en_hi | output | 1 | Odd-lane enable |
| ram_we_hi | output | 1 | Odd-lane write |
| ram_addr_hi | output | AW-1 | Odd-lane word address |
| ram_wdata_hi | output | 8 | Odd-lane write byte |
| ram_rdata_hi | input | 8 | Odd-lane read byte, one cycle after enable |

## Verification
The bench targets unaligned words, wrap at the top of RAM, read-after-write and the probe. A design that mixes up the lanes on an odd word would swap the two bytes or write the high byte into the wrong even word. A design that drops the wrap would send the high byte of the last word above the RAM instead of to address 0. The RAM model aliases addresses beyond a chosen physical size: a probe that stopped early, skipped the compare of its final read, or stepped sizes the wrong way would report the wrong size. Host requests issued during a probe are checked so that a leaking pointer load or a stray host_rvalid shows up.

// File: rtl/dport_pkg.sv
package dport_pkg;

    typedef enum logic [1:0] {
        SEL_WPTR = 2'd0,
        SEL_RPTR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } dport_sel_t;

    typedef enum logic [2:0] {
        SZ_IDLE  = 3'd0,
        SZ_CLEAR = 3'd1,
        SZ_FILL  = 3'd2,
        SZ_CHECK = 3'd3,
        SZ_JUDGE = 3'd4,
        SZ_DONE  = 3'd5
    } sz_state_t;

    localparam logic [15:0] PAT_FIRST = 16'd1;
    localparam logic [15:0] PAT_STEP  = 16'd3;

endpackage

// File: rtl/dport_ptr.sv
module dport_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          two,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (adv) begin
            // modulo 2^AW wrap comes from the register width
            ptr_q <= ptr_q + (two ? AW'(2) : AW'(1));
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/dport_lanes.sv
module dport_lanes #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          word,
    input  logic [15:0]   wdata,
    output logic          en_lo,
    output logic          en_hi,
    output logic [AW-2:0] addr_lo,
    output logic [AW-2:0] addr_hi,
    output logic [7:0]    wd_lo,
    output logic [7:0]    wd_hi
);
    localparam int LW = AW - 1;

    logic [LW-1:0] base;
    logic          odd;
    logic          split;

    always_comb begin
        base  = addr[AW-1:1];
        odd   = addr[0];
        split = word & odd;
        en_lo = word | ~odd;
        en_hi = word | odd;
        // odd word: high byte spills into the next even slot
        addr_lo = split ? base + LW'(1) : base;
        addr_hi = base;
        wd_lo   = split ? wdata[15:8] : wdata[7:0];
        wd_hi   = (word & ~odd) ? wdata[15:8] : wdata[7:0];
    end
endmodule

// File: rtl/dport_sizer.sv
module dport_sizer
    import dport_pkg::*;
#(
    parameter int MAX_BYTES  = 65536,
    parameter int STEP_BYTES = 16384,
    parameter int AW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   rdata,
    output logic          busy,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [15:0]   ram_wdata,
    output logic          done,
    output logic          ok,
    output logic [AW:0]   bytes
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] TRIAL_MAX  = CW'(MAX_BYTES);
    localparam logic [CW-1:0] TRIAL_STEP = CW'(STEP_BYTES);

    sz_state_t     state_q, state_d;
    logic [CW-1:0] trial_q;
    logic [AW-1:0] addr_q;
    logic [15:0]   pat_q;
    logic [15:0]   exp_q;
    logic          chk_v_q;
    logic          fail_q;
    logic          ok_q;
    logic [CW-1:0] bytes_q;
    logic          last;
    logic          mismatch;
    logic          fail_now;

    assign last     = ({1'b0, addr_q} + CW'(2)) == trial_q;
    assign mismatch = chk_v_q && (rdata != exp_q);
    assign fail_now = fail_q | mismatch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SZ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SZ_IDLE:  if (start) state_d = SZ_CLEAR;
            SZ_CLEAR: if (last)  state_d = SZ_FILL;
            SZ_FILL:  if (last)  state_d = SZ_CHECK;
            SZ_CHECK: if (last)  state_d = SZ_JUDGE;
            SZ_JUDGE: begin
                if (fail_now && trial_q != TRIAL_STEP) state_d = SZ_CLEAR;
                else                                   state_d = SZ_DONE;
            end
            SZ_DONE:  if (start) state_d = SZ_CLEAR;
            default:  state_d = SZ_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            addr_q  <= '0;
            pat_q   <= PAT_FIRST;
            exp_q   <= '0;
            chk_v_q <= 1'b0;
            fail_q  <= 1'b0;
            ok_q    <= 1'b0;
            bytes_q <= '0;
        end else begin
            chk_v_q <= 1'b0;
            if (chk_v_q) fail_q <= fail_now;
            unique case (state_q)
                SZ_IDLE, SZ_DONE: begin
                    if (start) begin
                        trial_q <= TRIAL_MAX;
                        addr_q  <= '0;
                        fail_q  <= 1'b0;
                        ok_q    <= 1'b0;
                        bytes_q <= '0;
                    end
                end
                SZ_CLEAR: begin
                    addr_q <= last ? '0 : addr_q + AW'(2);
                    pat_q  <= PAT_FIRST;
                end
                SZ_FILL: begin
                    addr_q <= last ? '0 : addr_q + AW'(2);
                    pat_q  <= last ? PAT_FIRST : pat_q + PAT_STEP;
                end
                SZ_CHECK: begin
                    addr_q  <= last ? '0 : addr_q + AW'(2);
                    pat_q   <= pat_q + PAT_STEP;
                    exp_q   <= pat_q;
                    chk_v_q <= 1'b1;
                end
                SZ_JUDGE: begin
                    addr_q <= '0;
                    fail_q <= 1'b0;
                    if (!fail_now) begin
                        ok_q    <= 1'b1;
                        bytes_q <= trial_q;
                    end else if (trial_q != TRIAL_STEP) begin
                        trial_q <= trial_q - TRIAL_STEP;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            SZ_IDLE:  ;
            SZ_CLEAR: begin busy = 1'b1; ram_en = 1'b1; ram_we = 1'b1; end
            SZ_FILL:  begin busy = 1'b1; ram_en = 1'b1; ram_we = 1'b1; ram_wdata = pat_q; end
            SZ_CHECK: begin busy = 1'b1; ram_en = 1'b1; end
            SZ_JUDGE: busy = 1'b1;
            SZ_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    assign ram_addr = addr_q;
    assign ok       = ok_q;
    assign bytes    = bytes_q;
endmodule

// File: rtl/dport_window.sv
module dport_window
    import dport_pkg::*;
#(
    parameter int MAX_BYTES  = 65536,
    parameter int STEP_BYTES = 16384,
    parameter int AW         = $clog2(MAX_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    input  logic          host_write,
    input  logic [1:0]    host_sel,
    input  logic          host_word,
    input  logic [15:0]   host_wdata,
    output logic          host_busy,
    output logic          host_rvalid,
    output logic [15:0]   host_rdata,
    input  logic          probe_start,
    output logic          probe_done,
    output logic          probe_ok,
    output logic [AW:0]   probe_bytes,
    output logic          ram_en_lo,
    output logic          ram_we_lo,
    output logic [AW-2:0] ram_addr_lo,
    output logic [7:0]    ram_wdata_lo,
    input  logic [7:0]    ram_rdata_lo,
    output logic          ram_en_hi,
    output logic          ram_we_hi,
    output logic [AW-2:0] ram_addr_hi,
    output logic [7:0]    ram_wdata_hi,
    input  logic [7:0]    ram_rdata_hi
);
    localparam int NPTR = 2;

    logic          sz_busy, sz_en, sz_we;
    logic [AW-1:0] sz_addr;
    logic [15:0]   sz_wdata;
    logic          host_acc, data_acc;
    logic [NPTR-1:0] ld, adv;
    logic [AW-1:0] ptrs [NPTR];
    logic [AW-1:0] m_addr;
    logic          m_word;
    logic [15:0]   m_wdata;
    logic          m_en_lo, m_en_hi, lane_en, lane_we;
    logic          rv_q, odd_q, word_q;

    assign host_acc = host_valid && !sz_busy;
    assign data_acc = host_acc && (host_sel == SEL_DATA);

    // index 0: write pointer, index 1: read pointer
    assign ld[0]  = host_acc && host_write && (host_sel == SEL_WPTR);
    assign ld[1]  = host_acc && host_write && (host_sel == SEL_RPTR);
    assign adv[0] = data_acc && host_write;
    assign adv[1] = data_acc && !host_write;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        dport_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[gi]),
            .load_val (host_wdata[AW-1:0]),
            .adv      (adv[gi]),
            .two      (host_word),
            .ptr      (ptrs[gi])
        );
    end

    dport_sizer #(.MAX_BYTES(MAX_BYTES), .STEP_BYTES(STEP_BYTES), .AW(AW)) u_sizer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (probe_start),
        .rdata     ({ram_rdata_hi, ram_rdata_lo}),
        .busy      (sz_busy),
        .ram_en    (sz_en),
        .ram_we    (sz_we),
        .ram_addr  (sz_addr),
        .ram_wdata (sz_wdata),
        .done      (probe_done),
        .ok        (probe_ok),
        .bytes     (probe_bytes)
    );

    always_comb begin
        if (sz_busy) begin
            m_addr  = sz_addr;
            m_word  = 1'b1;
            m_wdata = sz_wdata;
            lane_en = sz_en;
            lane_we = sz_we;
        end else begin
            m_addr  = host_write ? ptrs[0] : ptrs[1];
            m_word  = host_word;
            m_wdata = host_wdata;
            lane_en = data_acc;
            lane_we = host_write;
        end
    end

    dport_lanes #(.AW(AW)) u_lanes (
        .addr    (m_addr),
        .word    (m_word),
        .wdata   (m_wdata),
        .en_lo   (m_en_lo),
        .en_hi   (m_en_hi),
        .addr_lo (ram_addr_lo),
        .addr_hi (ram_addr_hi),
        .wd_lo   (ram_wdata_lo),
        .wd_hi   (ram_wdata_hi)
    );

    assign ram_en_lo = lane_en && m_en_lo;
    assign ram_en_hi = lane_en && m_en_hi;
    assign ram_we_lo = ram_en_lo && lane_we;
    assign ram_we_hi = ram_en_hi && lane_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv_q   <= 1'b0;
            odd_q  <= 1'b0;
            word_q <= 1'b0;
        end else begin
            rv_q   <= data_acc && !host_write;
            odd_q  <= ptrs[1][0];
            word_q <= host_word;
        end
    end

    always_comb begin
        unique case ({word_q, odd_q})
            2'b00:   host_rdata = {8'h00, ram_rdata_lo};
            2'b01:   host_rdata = {8'h00, ram_rdata_hi};
            2'b10:   host_rdata = {ram_rdata_hi, ram_rdata_lo};
            default: host_rdata = {ram_rdata_lo, ram_rdata_hi};
        endcase
    end

    assign host_rvalid = rv_q;
    assign host_busy   = sz_busy;
endmodule

// File: rtl/dport_window_chk.sv
module dport_window_chk #(
    parameter int AW = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic        host_write,
    input logic [1:0]  host_sel,
    input logic        host_word,
    input logic        host_busy,
    input logic        host_rvalid,
    input logic        probe_start,
    input logic        probe_done,
    input logic        probe_ok,
    input logic [AW:0] probe_bytes,
    input logic        ram_en_lo,
    input logic        ram_en_hi,
    input logic        ram_we_lo,
    input logic        ram_we_hi
);
    logic hdata;
    assign hdata = host_valid && !host_busy && (host_sel == 2'd2);

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        hdata && !host_word |-> $countones({ram_en_lo, ram_en_hi}) == 1); // R2

    AST_WORD_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        hdata && host_word |-> ram_en_lo && ram_en_hi); // R3

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        hdata && !host_write |=> host_rvalid); // R6

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdata && !host_write) |=> !host_rvalid); // R11

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hdata && !host_write |-> !ram_we_lo && !ram_we_hi); // R6

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !probe_done); // R9

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done && !probe_start |=> $stable(probe_bytes) && $stable(probe_ok)); // R9

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done && !probe_ok |-> probe_bytes == '0); // R10
endmodule

bind dport_window dport_window_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_sel    (host_sel),
    .host_word   (host_word),
    .host_busy   (host_busy),
    .host_rvalid (host_rvalid),
    .probe_start (probe_start),
    .probe_done  (probe_done),
    .probe_ok    (probe_ok),
    .probe_bytes (probe_bytes),
    .ram_en_lo   (ram_en_lo),
    .ram_en_hi   (ram_en_hi),
    .ram_we_lo   (ram_we_lo),
    .ram_we_hi   (ram_we_hi)
);

// File: tb/dport_window_tb_top.sv
module dport_window_tb_top;
    localparam int MAXB = 256;
    localparam int STEPB = 64;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_valid = 1'b0, host_write = 1'b0, host_word = 1'b0;
    logic [1:0] host_sel = 2'd3;
    logic [15:0] host_wdata = '0;
    logic host_busy, host_rvalid;
    logic [15:0] host_rdata;
    logic probe_start = 1'b0;
    logic probe_done, probe_ok;
    logic [AW:0] probe_bytes;
    logic ram_en_lo, ram_we_lo, ram_en_hi, ram_we_hi;
    logic [AW-2:0] ram_addr_lo, ram_addr_hi;
    logic [7:0] ram_wdata_lo, ram_wdata_hi;
    logic [7:0] ram_rdata_lo = '0, ram_rdata_hi = '0;

    int total = 0, bad = 0;
    int phys = MAXB;
    logic [7:0] mem [MAXB];
    logic [7:0] shadow [MAXB];
    int wp = 0, rp = 0;
    bit exp_rd = 0;
    logic [15:0] exp_val = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    dport_window #(.MAX_BYTES(MAXB), .STEP_BYTES(STEPB)) dut_i (.*);

    // RAM model: physical size phys, higher addresses alias
    always @(posedge clk) begin
        if (ram_en_lo) begin
            if (ram_we_lo) mem[(int'(ram_addr_lo) * 2) % phys] <= ram_wdata_lo;
            else ram_rdata_lo <= mem[(int'(ram_addr_lo) * 2) % phys];
        end
        if (ram_en_hi) begin
            if (ram_we_hi) mem[(int'(ram_addr_hi) * 2 + 1) % phys] <= ram_wdata_hi;
            else ram_rdata_hi <= mem[(int'(ram_addr_hi) * 2 + 1) % phys];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // per-clock comparison of the read return against the model
    initial begin
        forever begin
            bit e;
            logic [15:0] v;
            @(posedge clk);
            e = exp_rd;
            v = exp_val;
            #2;
            if (rst_n) begin
                chk("R6 rvalid", {31'b0, host_rvalid}, {31'b0, e});
                if (e) chk("R6 rdata", {16'b0, host_rdata}, {16'b0, v});
            end
        end
    end

    task automatic op(input logic [1:0] sel, input bit wr, input bit wd,
                      input logic [15:0] d, input bit ign);
        @(negedge clk);
        host_valid = 1'b1; host_sel = sel; host_write = wr;
        host_word = wd; host_wdata = d;
        exp_rd = 0;
        if (!ign) begin
            if (wr && sel == 2'd0) wp = int'(d) % MAXB;
            else if (wr && sel == 2'd1) rp = int'(d) % MAXB;
            else if (sel == 2'd2 && wr) begin
                shadow[wp] = d[7:0];
                if (wd) shadow[(wp + 1) % MAXB] = d[15:8];
                wp = (wp + (wd ? 2 : 1)) % MAXB;
            end else if (sel == 2'd2) begin
                exp_val = wd ? {shadow[(rp + 1) % MAXB], shadow[rp]} : {8'h00, shadow[rp]};
                exp_rd = 1;
                rp = (rp + (wd ? 2 : 1)) % MAXB;
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        host_valid = 1'b0; host_sel = 2'd3; exp_rd = 0;
    endtask

    task automatic run_probe(input int p, input bit ok_e, input int bytes_e, input string tag);
        int n;
        phys = p;
        @(negedge clk); probe_start = 1'b1;
        @(negedge clk); probe_start = 1'b0;
        n = 0;
        while (!probe_done && n < 20000) begin @(negedge clk); n++; end
        chk({tag, " probe_ok"}, {31'b0, probe_ok}, {31'b0, ok_e});
        chk({tag, " probe_bytes"}, {23'b0, probe_bytes}, bytes_e);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAXB; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 busy", {31'b0, host_busy}, 0);
        chk("R12 rvalid", {31'b0, host_rvalid}, 0);
        chk("R12 done", {31'b0, probe_done}, 0);
        chk("R12 bytes", {23'b0, probe_bytes}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12/R3: pointers start at 0; word write then read-after-write (R6)
        op(2'd2, 1, 1, 16'hBEEF, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        op(2'd2, 1, 1, 16'h1234, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        // R1: independent pointers, R2 byte accesses
        op(2'd0, 1, 0, 16'h0040, 0);
        op(2'd1, 1, 0, 16'h0041, 0);
        op(2'd2, 1, 0, 16'h0011, 0);
        op(2'd2, 1, 0, 16'h0022, 0);
        op(2'd2, 1, 0, 16'h0033, 0);
        op(2'd2, 0, 0, 16'h0, 0);
        op(2'd2, 0, 0, 16'h0, 0);
        op(2'd1, 1, 0, 16'h0040, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        // R1: sel 3 and pointer-register reads have no effect, no rvalid
        op(2'd3, 1, 1, 16'h0077, 0);
        op(2'd0, 0, 1, 16'h0, 0);
        op(2'd2, 0, 0, 16'h0, 0);
        // R4: odd word
        op(2'd0, 1, 0, 16'h0051, 0);
        op(2'd2, 1, 1, 16'hA1B2, 0);
        op(2'd1, 1, 0, 16'h0050, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        op(2'd2, 0, 0, 16'h0, 0);
        op(2'd1, 1, 0, 16'h0051, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        // R5: wrap at the top address
        op(2'd0, 1, 0, 16'h00FF, 0);
        op(2'd2, 1, 1, 16'hC3D4, 0);
        op(2'd2, 1, 1, 16'h5566, 0);
        op(2'd1, 1, 0, 16'h00FF, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        op(2'd2, 0, 1, 16'h0, 0);
        // R7: 24-bit value at an odd address, low word first
        op(2'd0, 1, 0, 16'h0061, 0);
        op(2'd2, 1, 1, 16'hCDEF, 0);
        op(2'd2, 1, 1, 16'h00AB, 0);
        op(2'd1, 1, 0, 16'h0061, 0);
        for (int i = 0; i < 4; i++) op(2'd2, 0, 0, 16'h0, 0);
        // R8: leading byte, two words, trailing byte from offset 0x71
        op(2'd0, 1, 0, 16'h0071, 0);
        op(2'd2, 1, 0, 16'h0091, 0);
        op(2'd2, 1, 1, 16'h9392, 0);
        op(2'd2, 1, 1, 16'h9594, 0);
        op(2'd2, 1, 0, 16'h0096, 0);
        op(2'd1, 1, 0, 16'h0070, 0);
        for (int i = 0; i < 4; i++) op(2'd2, 0, 1, 16'h0, 0);
        idle();
        idle();
        // R9: physical 128 of 256 -> 128 detected
        run_probe(128, 1, 128, "R9");
        // R10: physical 32, smaller than the smallest trial -> none
        run_probe(32, 0, 0, "R10");
        // R11: host requests during a probe are ignored
        op(2'd1, 1, 0, 16'h0010, 0);
        idle();
        phys = MAXB;
        @(negedge clk); probe_start = 1'b1;
        @(negedge clk); probe_start = 1'b0;
        chk("R11 busy", {31'b0, host_busy}, 1);
        op(2'd1, 1, 0, 16'h0030, 1);
        op(2'd0, 1, 0, 16'h0031, 1);
        op(2'd2, 0, 1, 16'h0, 1);
        idle();
        begin
            int n = 0;
            while (!probe_done && n < 20000) begin @(negedge clk); n++; end
        end
        chk("R9 full ok", {31'b0, probe_ok}, 1);
        chk("R9 full bytes", {23'b0, probe_bytes}, MAXB);
        for (int i = 0; i < MAXB / 2; i++) begin
            shadow[2 * i]     = 8'((1 + 3 * i) & 255);
            shadow[2 * i + 1] = 8'((1 + 3 * i) >> 8);
        end
        // R11: read pointer kept 0x10 -> pattern word 8; write pointer kept
        op(2'd2, 0, 1, 16'h0, 0);
        op(2'd2, 1, 0, 16'h00E7, 0);
        op(2'd1, 1, 0, 16'h0031, 0);
        op(2'd1, 1, 0, int'(wp - 1) % MAXB, 0);
        op(2'd2, 0, 0, 16'h0, 0);
        idle();
        idle();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule